// File: doc/BRIEF.md
# DMA Trigger and Control Sequencer

This block is the control front end of a descriptor-driven DMA engine. Software works it through a small register port. A transfer is launched in one of two ways: by a software start write, or by a vertical-blank pulse when the block is set to frame-synchronous triggering. In that mode an optional single-shot latch lets one vblank through and then blocks the rest. Software rearms the latch with a separate write.

The engine reports the end of its work with a done pulse and the number of bytes it moved. The block then holds back the completion interrupt for a time proportional to that byte count. The scale is one byte time of a 2 Mbit/s serial link, measured in core clocks. When the delay runs out, the block clears its software status bit. It raises the done interrupt only if the engine is still enabled and no abort has been recorded.

If software clears the enable while a software-started transfer is still marked busy, the block records a sticky abort flag. Software can read that flag and clears it by writing to it.

Top module: `dma_trig_seq`

## Requirements
- R1: After reset the register port reads these values. Address 0 (enable) reads 0, address 1 (start/status) reads 0, address 2 (vblank select) reads 0 and address 3 (single-shot pending) reads 0. Address 4 (system control) reads 0x3A980000, address 5 (protection) reads 0x00007F00, address 6 (mode) reads 0x00000001 and address 7 (abort) reads 0.
- R2: Writing a value with bit 0 set to address 1 launches a transfer only when bit 0 of address 0 is 1. A launch gives a one-cycle `eng_start` pulse in the cycle after the write and sets bit 0 of address 1. With the enable at 0 the write has no effect.
- R3: When bit 0 of address 0 and bit 0 of address 2 are both 1 and the block is idle, a one-cycle `vblank` pulse launches a transfer (`eng_start` pulses in the next cycle) and leaves bit 0 of address 1 at 0.
- R4: If bit 12 of address 4 is 1, a vblank launch sets the pending flag (bit 0 of address 3). While that flag is set, vblank pulses launch nothing.
- R5: Writing a value with bit 0 set to address 3 clears the pending flag. Writing 0 to bit 0 of address 2 clears it as well.
- R6: With K core clocks per byte, derived from the core frequency and the link rate, `irq_done` rises exactly N*K+1 cycles after the clock edge that samples `eng_done` with `eng_bytes`=N. It stays high for one cycle.
- R7: When the delay expires, bit 0 of address 1 is cleared. If bit 0 of address 0 is 0 at that point, no interrupt is raised.
- R8: Writing 0 to bit 0 of address 0 while bit 0 of address 1 is 1 sets a sticky abort flag, read at bit 0 of address 7. Re-enabling does not clear the flag, and while it is set completions raise no interrupt. Writing a value with bit 0 set to address 7 clears it.
- R9: While a transfer is in flight (launch to delay expiry), further start writes and vblank pulses launch nothing.
- R10: Addresses 4, 5 and 6 are plain 32-bit read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| vblank | input | 1 | Vertical-blank pulse |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_done | input | 1 | Engine finished pulse |
| eng_bytes | input | BYTE_W | Bytes moved, valid with eng_done |
| irq_done | output | 1 | One-cycle completion interrupt |

## Verification
The bench sweeps every byte count from 0 to 15 through both launch paths and checks the interrupt cycle by cycle. A counter that is off by one, or that skips the zero-length case, either fires a cycle early or late, or never fires. It runs the single-shot latch through block, rearm-by-shot-write and clear-by-deselect, which catches a latch that never sets or one that only one of the two paths clears. The abort path is driven both with and without re-enabling before completion. A design that lets the enable bit alone gate the interrupt would wrongly fire after the re-enable. A disabled completion of a vblank transfer catches an interrupt that ignores the enable.

// File: rtl/dts_pkg.sv
package dts_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        RA_EN    = 3'd0,
        RA_START = 3'd1,
        RA_TRIG  = 3'd2,
        RA_SHOT  = 3'd3,
        RA_SYS   = 3'd4,
        RA_PROT  = 3'd5,
        RA_MODE  = 3'd6,
        RA_ABORT = 3'd7
    } reg_addr_e;

    localparam logic [DATA_W-1:0] SYS_RST  = 32'h3A98_0000;
    localparam logic [DATA_W-1:0] PROT_RST = 32'h0000_7F00;
    localparam logic [DATA_W-1:0] MODE_RST = 32'h0000_0001;
    localparam int SINGLE_BIT = 12;
endpackage

// File: rtl/dts_regs.sv
module dts_regs
    import dts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic              pending_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o,
    output logic              trig_o,
    output logic              single_o,
    output logic              abort_o,
    output logic              start_req_o,
    output logic              shot_clr_o
);
    typedef struct packed {
        logic              en;
        logic              trig;
        logic              abort;
        logic [DATA_W-1:0] sys;
        logic [DATA_W-1:0] prot;
        logic [DATA_W-1:0] mode;
    } regs_t;

    regs_t r_d, r_q;
    logic  abort_clr;

    always_comb begin
        r_d       = r_q;
        abort_clr = wr_i && (addr_i == RA_ABORT) && wdata_i[0];
        if (wr_i) begin
            case (addr_i)
                RA_EN: begin
                    r_d.en = wdata_i[0];
                    if (!wdata_i[0] && busy_i) r_d.abort = 1'b1;
                end
                RA_TRIG: r_d.trig = wdata_i[0];
                RA_SYS:  r_d.sys  = wdata_i;
                RA_PROT: r_d.prot = wdata_i;
                RA_MODE: r_d.mode = wdata_i;
                RA_ABORT: if (wdata_i[0]) r_d.abort = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en    <= 1'b0;
            r_q.trig  <= 1'b0;
            r_q.abort <= 1'b0;
            r_q.sys   <= SYS_RST;
            r_q.prot  <= PROT_RST;
            r_q.mode  <= MODE_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RA_EN:    rdata_o[0] = r_q.en;
            RA_START: rdata_o[0] = busy_i;
            RA_TRIG:  rdata_o[0] = r_q.trig;
            RA_SHOT:  rdata_o[0] = pending_i;
            RA_SYS:   rdata_o    = r_q.sys;
            RA_PROT:  rdata_o    = r_q.prot;
            RA_MODE:  rdata_o    = r_q.mode;
            RA_ABORT: rdata_o[0] = r_q.abort;
            default:  rdata_o    = '0;
        endcase
    end

    assign en_o        = r_q.en;
    assign trig_o      = r_q.trig;
    assign single_o    = r_q.sys[SINGLE_BIT];
    assign abort_o     = r_q.abort;
    assign start_req_o = wr_i && (addr_i == RA_START) && wdata_i[0];
    assign shot_clr_o  = wr_i && (addr_i == RA_SHOT) && wdata_i[0];

    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.abort && !abort_clr) |=> r_q.abort); // R8
endmodule

// File: rtl/dts_launch.sv
module dts_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic trig_i,
    input  logic single_i,
    input  logic abort_i,
    input  logic start_req_i,
    input  logic shot_clr_i,
    input  logic vblank_i,
    input  logic expire_i,
    output logic start_o,
    output logic busy_o,
    output logic active_o,
    output logic pending_o,
    output logic irq_o
);
    typedef struct packed {
        logic busy;
        logic active;
        logic pending;
        logic start;
        logic irq;
    } lst_t;

    lst_t s_d, s_q;
    logic go_sw, go_vb;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.irq   = 1'b0;
        go_sw = start_req_i && en_i && !s_q.active;
        go_vb = !go_sw && vblank_i && en_i && trig_i && !s_q.pending && !s_q.active;

        if (!trig_i || shot_clr_i) s_d.pending = 1'b0;

        if (go_sw) begin
            s_d.start  = 1'b1;
            s_d.busy   = 1'b1;
            s_d.active = 1'b1;
        end else if (go_vb) begin
            s_d.start   = 1'b1;
            s_d.busy    = 1'b0;
            s_d.active  = 1'b1;
            s_d.pending = single_i;
        end

        if (expire_i) begin
            s_d.active = 1'b0;
            s_d.busy   = 1'b0;
            s_d.irq    = en_i && !abort_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_o   = s_q.start;
    assign busy_o    = s_q.busy;
    assign active_o  = s_q.active;
    assign pending_o = s_q.pending;
    assign irq_o     = s_q.irq;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> $past(en_i)); // R7
    AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pending && trig_i && !start_req_i && !shot_clr_i) |=> !s_q.start); // R4
    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !expire_i) |=> !s_q.start); // R9
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |=> !s_q.irq); // R6
endmodule

// File: rtl/dts_delay.sv
module dts_delay #(
    parameter int BYTE_W       = 16,
    parameter int CYC_PER_BYTE = 762
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] bytes_i,
    output logic              expire_o
);
    localparam int MUL_W = $clog2(CYC_PER_BYTE + 1);
    localparam int CNT_W = BYTE_W + MUL_W;
    localparam logic [CNT_W-1:0] CYC_L = CNT_W'(CYC_PER_BYTE);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } dly_t;

    dly_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (!d_q.run) begin
            if (active_i && done_i) begin
                d_d.run = 1'b1;
                d_d.cnt = CNT_W'(bytes_i) * CYC_L;
            end
        end else if (d_q.cnt == '0) begin
            d_d.run = 1'b0;
        end else begin
            d_d.cnt = d_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign expire_o = d_q.run && (d_q.cnt == '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.run && d_q.cnt != '0) |=> (d_q.run && d_q.cnt == $past(d_q.cnt) - 1'b1)); // R6
    AST_RUN_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.run |-> active_i); // R9
endmodule

// File: rtl/dma_trig_seq.sv
module dma_trig_seq
    import dts_pkg::*;
#(
    parameter int CORE_HZ  = 200_000_000,
    parameter int LINK_BPS = 2_097_152,
    parameter int BYTE_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              vblank,
    output logic              eng_start,
    input  logic              eng_done,
    input  logic [BYTE_W-1:0] eng_bytes,
    output logic              irq_done
);
    localparam int BYTES_PER_SEC = LINK_BPS / 8;
    localparam int CYC_PER_BYTE  = CORE_HZ / BYTES_PER_SEC;

    logic en, trig, single, abort, start_req, shot_clr;
    logic busy, active, pending, expire;

    dts_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .busy_i     (busy),
        .pending_i  (pending),
        .rdata_o    (reg_rdata),
        .en_o       (en),
        .trig_o     (trig),
        .single_o   (single),
        .abort_o    (abort),
        .start_req_o(start_req),
        .shot_clr_o (shot_clr)
    );

    dts_launch u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .trig_i     (trig),
        .single_i   (single),
        .abort_i    (abort),
        .start_req_i(start_req),
        .shot_clr_i (shot_clr),
        .vblank_i   (vblank),
        .expire_i   (expire),
        .start_o    (eng_start),
        .busy_o     (busy),
        .active_o   (active),
        .pending_o  (pending),
        .irq_o      (irq_done)
    );

    dts_delay #(
        .BYTE_W      (BYTE_W),
        .CYC_PER_BYTE(CYC_PER_BYTE)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .done_i  (eng_done),
        .bytes_i (eng_bytes),
        .expire_o(expire)
    );

    AST_START_IDLE_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(!active)); // R9
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(en)); // R2
endmodule

// File: tb/tb_dma_trig_seq.sv
module tb_dma_trig_seq;
    localparam int BW  = 8;
    localparam int CPB = 3; // 48 Hz core / (128 bit/s / 8)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          vblank = 1'b0;
    logic          eng_start;
    logic          eng_done = 1'b0;
    logic [BW-1:0] eng_bytes = '0;
    logic          irq_done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dma_trig_seq #(.CORE_HZ(48), .LINK_BPS(128), .BYTE_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vblank(vblank),
        .eng_start(eng_start), .eng_done(eng_done), .eng_bytes(eng_bytes),
        .irq_done(irq_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_vb();
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0;
    endtask

    // engine done with n bytes; checks interrupt timing (R6)
    task automatic finish(input string tag, input int n, input logic exp_irq);
        @(negedge clk);
        eng_done = 1'b1; eng_bytes = BW'(n);
        @(negedge clk);
        eng_done = 1'b0;
        chk({tag, " R6 early"}, 32'(irq_done), 32'd0);
        for (int i = 0; i < n * CPB; i++) begin
            @(negedge clk);
            chk({tag, " R6 early"}, 32'(irq_done), 32'd0);
        end
        @(negedge clk);
        chk({tag, " R6/R7 irq"}, 32'(irq_done), 32'(exp_irq));
        @(negedge clk);
        chk({tag, " R6 pulse"}, 32'(irq_done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd_chk("R1 en",    3'd0, 32'h0);
        rd_chk("R1 start", 3'd1, 32'h0);
        rd_chk("R1 trig",  3'd2, 32'h0);
        rd_chk("R1 shot",  3'd3, 32'h0);
        rd_chk("R1 sys",   3'd4, 32'h3A98_0000);
        rd_chk("R1 prot",  3'd5, 32'h0000_7F00);
        rd_chk("R1 mode",  3'd6, 32'h0000_0001);
        rd_chk("R1 abort", 3'd7, 32'h0);

        // R10 plain registers
        wr(3'd5, 32'hDEAD_BEEF); rd_chk("R10 prot", 3'd5, 32'hDEAD_BEEF);
        wr(3'd6, 32'h1234_5670); rd_chk("R10 mode", 3'd6, 32'h1234_5670);

        // R2 start ignored while disabled
        wr(3'd1, 32'h1);
        chk("R2 no start when off", 32'(eng_start), 32'd0);
        rd_chk("R2 status off", 3'd1, 32'h0);

        // R2/R9/R6 software launches, byte sweep
        wr(3'd0, 32'h1);
        for (int n = 0; n < 16; n++) begin
            wr(3'd1, 32'h1);
            chk("R2 start pulse", 32'(eng_start), 32'd1);
            rd_chk("R2 status set", 3'd1, 32'h1);
            wr(3'd1, 32'h1);
            chk("R9 no relaunch", 32'(eng_start), 32'd0);
            finish("sw", n, 1'b1);
            rd_chk("R7 status clear", 3'd1, 32'h0);
        end

        // R3 vblank launches, byte sweep, no single-shot
        wr(3'd2, 32'h1);
        for (int n = 0; n < 16; n++) begin
            pulse_vb();
            chk("R3 vb start", 32'(eng_start), 32'd1);
            rd_chk("R3 status stays 0", 3'd1, 32'h0);
            rd_chk("R4 no pending", 3'd3, 32'h0);
            pulse_vb();
            chk("R9 vb ignored in flight", 32'(eng_start), 32'd0);
            finish("vb", n, 1'b1);
        end

        // R4/R5 single-shot
        wr(3'd4, 32'h3A98_1000);
        pulse_vb();
        chk("R4 first vb", 32'(eng_start), 32'd1);
        rd_chk("R4 pending set", 3'd3, 32'h1);
        finish("ss", 2, 1'b1);
        pulse_vb();
        chk("R4 blocked", 32'(eng_start), 32'd0);
        wr(3'd3, 32'h1);
        rd_chk("R5 shot clears", 3'd3, 32'h0);
        pulse_vb();
        chk("R5 rearmed vb", 32'(eng_start), 32'd1);
        finish("ss2", 1, 1'b1);
        rd_chk("R4 pending again", 3'd3, 32'h1);
        wr(3'd2, 32'h0);
        @(negedge clk);
        rd_chk("R5 deselect clears", 3'd3, 32'h0);
        wr(3'd4, 32'h3A98_0000);

        // R7 disabled completion of a vblank transfer (no abort)
        wr(3'd2, 32'h1);
        pulse_vb();
        chk("R3 vb start 2", 32'(eng_start), 32'd1);
        wr(3'd0, 32'h0);
        rd_chk("R8 no abort when status 0", 3'd7, 32'h0);
        finish("off", 3, 1'b0);
        wr(3'd2, 32'h0);

        // R8 abort
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h1);
        chk("R2 start for abort", 32'(eng_start), 32'd1);
        wr(3'd0, 32'h0);
        rd_chk("R8 abort set", 3'd7, 32'h1);
        finish("abort", 2, 1'b0);
        rd_chk("R7 status clear abort", 3'd1, 32'h0);
        wr(3'd0, 32'h1);
        rd_chk("R8 sticky", 3'd7, 32'h1);
        wr(3'd1, 32'h1);
        finish("abort re-en", 1, 1'b0);
        wr(3'd7, 32'h1);
        rd_chk("R8 cleared", 3'd7, 32'h0);
        wr(3'd1, 32'h1);
        finish("after clear", 1, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule